// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a slave serial port that keeps a 20-bit configuration word for a camera-style device. An external host drives a serial clock, a serial data line and a latch strobe. The block samples all three through synchronizers into a fast system clock domain. It acts only on detected rising edges of the serial clock. Every transfer carries 22 bits. The first 20 are a data word, sent most significant bit first. The last two are a read/write trailer. The latch strobe is raised for the final trailer bit, and that bit marks the end of the transfer.

A write (trailer 00) copies the received word into the configuration register. Every latched transfer, whatever its trailer, causes the following serial clock rising edge to load the register into the shift register. The register then shifts back out on the data output, most significant bit first, while the host clocks in the next transfer. The edge that performs this load is consumed by it. The bit presented at that edge is not captured, so the host leaves one idle clock between transfers.

A 3-bit field of the register, bits [7:5], selects the output source. When the field is zero, the data output carries the readback bit. When it is nonzero, the data output carries one bit of a 7-bit test-signal input, and the readback is not transmitted.

Top module: `ser_cfg_port`

## Requirements
- R1: After the active-low asynchronous reset, the configuration register, the shift register and both trailer capture bits are zero, so `cfg_o` reads 0 and `sdout_o` reads 0.
- R2: When a 22-bit transfer ends with trailer bits 00 and the latch strobe is high on the 22nd rising edge, `cfg_o` takes the 20 data bits, with the first bit sent landing in bit 19.
- R3: A latched transfer with trailer 11 (read) leaves `cfg_o` unchanged.
- R4: A latched transfer with a mixed trailer (01 or 10) leaves `cfg_o` unchanged.
- R5: A 22-bit transfer during which the latch strobe is never high leaves `cfg_o` unchanged, even when its trailer is 00.
- R6: On the first serial clock rising edge after a latched edge, the shift register is loaded from the configuration register. With bits [7:5] equal to 0, `sdout_o` then shows register bit 19. The data bit presented at that edge is discarded.
- R7: After the load, each further serial clock rising edge shifts the readback by one place, so after k such edges (k < 20) `sdout_o` shows register bit 19-k. This readback continues while the next transfer is being received.
- R8: When bits [7:5] hold a value s from 1 to 7, `sdout_o` equals `test_sig_i[s-1]` and follows that input directly. When the field is 0, `test_sig_i` has no effect on `sdout_o`.
- R9: Changes on the data line or the latch strobe while the serial clock stays low change neither `cfg_o` nor `sdout_o`. The shift register and the configuration register change only after a detected serial clock rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock from the host |
| sdin_i | input | 1 | Serial data from the host |
| slat_i | input | 1 | Latch strobe, high on the last trailer bit |
| test_sig_i | input | 7 | Test signals routed to the output in test mode |
| sdout_o | output | 1 | Serial data output (readback or test signal) |
| cfg_o | output | 20 | Current configuration register contents |

## Verification
Two events can land on the same serial edge. The write into the configuration register and the shift of the last received bit happen together on the latched edge. On the next edge, the load of the new value into the shift register takes over the output. The bench provokes both by writing a word and, with no spare transfer in between, reading it back bit by bit during the following read transfer, so the readback must already show the freshly written value. It also writes values that switch bits [7:5] between zero and nonzero. This checks that the output source changes together with the register update.

// File: rtl/scp_pkg.sv
package scp_pkg;
   // One serial-domain event as seen in the system clock domain
   typedef struct packed {
      logic rise;   // serial clock rising edge detected this cycle
      logic din;    // synchronized data bit
      logic lat;    // synchronized latch strobe
   } scp_evt_t;
endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("scp_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] stage_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stage_q[s] <= '0;
            end else if (s == 0) begin
               stage_q[s] <= async_i;
            end else begin
               stage_q[s] <= stage_q[(s > 0) ? s-1 : 0];
            end
         end
      end
   endgenerate

   assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/scp_core.sv
module scp_core
   import scp_pkg::*;
#(
   parameter int DATA_W = 20,
   parameter int RW_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  scp_evt_t          evt_i,
   output logic [DATA_W-1:0] cfg_q,
   output logic [DATA_W-1:0] sreg_q,
   output logic [RW_W-1:0]   rw_q,
   output logic              load_pend_q
);
   generate
      if (RW_W < 2) begin : g_bad_rw
         $error("scp_core: RW_W must be at least 2");
      end
      if (DATA_W < 2) begin : g_bad_dw
         $error("scp_core: DATA_W must be at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] data_nx;
   logic [RW_W-1:0]   rw_nx;
   logic              wr_hit;

   // The chain runs data <- trailer <- din, so after a full transfer
   // the data word sits in sreg_q and the trailer in rw_q.
   assign data_nx = {sreg_q[DATA_W-2:0], rw_q[RW_W-1]};
   assign rw_nx   = {rw_q[RW_W-2:0], evt_i.din};
   assign wr_hit  = evt_i.lat && (rw_nx == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q       <= '0;
         sreg_q      <= '0;
         rw_q        <= '0;
         load_pend_q <= 1'b0;
      end else if (evt_i.rise) begin
         if (load_pend_q) begin
            sreg_q      <= cfg_q;
            load_pend_q <= 1'b0;
         end else begin
            sreg_q <= data_nx;
            rw_q   <= rw_nx;
            if (evt_i.lat) begin
               load_pend_q <= 1'b1;
            end
            if (wr_hit) begin
               cfg_q <= data_nx;
            end
         end
      end
   end
endmodule

// File: rtl/scp_omux.sv
module scp_omux #(
   parameter int SEL_W  = 3,
   localparam int N_SRC  = 1 << SEL_W,
   localparam int TEST_W = N_SRC - 1
) (
   input  logic [SEL_W-1:0]  sel_i,
   input  logic              ser_bit_i,
   input  logic [TEST_W-1:0] test_i,
   output logic              out_o
);
   logic [N_SRC-1:0] src;

   generate
      for (genvar i = 0; i < N_SRC; i++) begin : g_src
         if (i == 0) begin : g_ser
            assign src[i] = ser_bit_i;
         end else begin : g_tst
            assign src[i] = test_i[i-1];
         end
      end
   endgenerate

   assign out_o = src[sel_i];
endmodule

// File: rtl/ser_cfg_port.sv
module ser_cfg_port
   import scp_pkg::*;
#(
   parameter int DATA_W      = 20,
   parameter int RW_W        = 2,
   parameter int SEL_LSB     = 5,
   parameter int SEL_W       = 3,
   parameter int SYNC_STAGES = 2,
   localparam int TEST_W     = (1 << SEL_W) - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_i,
   input  logic              sdin_i,
   input  logic              slat_i,
   input  logic [TEST_W-1:0] test_sig_i,
   output logic              sdout_o,
   output logic [DATA_W-1:0] cfg_o
);
   generate
      if (SEL_LSB + SEL_W > DATA_W) begin : g_bad_sel
         $error("ser_cfg_port: select field exceeds register width");
      end
   endgenerate

   logic [2:0]        sync_w;
   logic              sclk_prev_q;
   scp_evt_t          evt_w;
   logic              rise_w;
   logic [DATA_W-1:0] sreg_w;
   logic [RW_W-1:0]   rw_w;
   logic              load_pend_w;
   logic [SEL_W-1:0]  sel_w;

   scp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .async_i({sclk_i, sdin_i, slat_i}),
      .sync_o (sync_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_prev_q <= 1'b0;
      else        sclk_prev_q <= sync_w[2];
   end

   assign rise_w    = sync_w[2] & ~sclk_prev_q;
   assign evt_w     = '{rise: rise_w, din: sync_w[1], lat: sync_w[0]};

   scp_core #(.DATA_W(DATA_W), .RW_W(RW_W)) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt_i      (evt_w),
      .cfg_q      (cfg_o),
      .sreg_q     (sreg_w),
      .rw_q       (rw_w),
      .load_pend_q(load_pend_w)
   );

   assign sel_w = cfg_o[SEL_LSB +: SEL_W];

   scp_omux #(.SEL_W(SEL_W)) u_omux (
      .sel_i    (sel_w),
      .ser_bit_i(sreg_w[DATA_W-1]),
      .test_i   (test_sig_i),
      .out_o    (sdout_o)
   );
endmodule

// File: rtl/scp_chk.sv
module scp_chk #(
   parameter int DATA_W  = 20,
   parameter int RW_W    = 2,
   parameter int SEL_LSB = 5,
   parameter int SEL_W   = 3,
   localparam int TEST_W = (1 << SEL_W) - 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rise,
   input logic              lat,
   input logic              load_pend,
   input logic [RW_W-1:0]   rw,
   input logic [DATA_W-1:0] sreg,
   input logic [DATA_W-1:0] cfg,
   input logic [TEST_W-1:0] test_sig,
   input logic              sdout
);
   logic [SEL_W-1:0] sel;
   assign sel = cfg[SEL_LSB +: SEL_W];

   // R2 R3 R4 R5: the register moves only on a latched edge with a 00 trailer
   a_r2_write_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cfg) |-> ($past(rise) && $past(lat) && rw == '0));

   // R6: the edge after a latched edge loads the register into the shifter
   a_r6_load: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && load_pend) |=> (sreg == cfg && !load_pend));

   // R7: ordinary edges shift the readback by one place
   a_r7_shift: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && !load_pend) |=> (sreg[DATA_W-1:1] == $past(sreg[DATA_W-2:0])));

   // R8: output source follows the select field
   a_r8_test_route: assert property (@(posedge clk) disable iff (!rst_n)
      (sel != '0) |-> (sdout == test_sig[int'(sel) - 1]));
   a_r8_readback_route: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == '0) |-> (sdout == sreg[DATA_W-1]));

   // R9: no state motion without a detected serial clock edge
   a_r9_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(sreg) || !$stable(rw)) |-> $past(rise));
endmodule

bind ser_cfg_port scp_chk #(
   .DATA_W (DATA_W),
   .RW_W   (RW_W),
   .SEL_LSB(SEL_LSB),
   .SEL_W  (SEL_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rise     (rise_w),
   .lat      (evt_w.lat),
   .load_pend(load_pend_w),
   .rw       (rw_w),
   .sreg     (sreg_w),
   .cfg      (cfg_o),
   .test_sig (test_sig_i),
   .sdout    (sdout_o)
);

// File: tb/ser_cfg_port_tb.sv
module ser_cfg_port_tb;
   localparam int DW   = 20;
   localparam int HALF = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sclk = 1'b0;
   logic          sdin = 1'b0;
   logic          slat = 1'b0;
   logic [6:0]    tsig = '0;
   logic          sdout;
   logic [DW-1:0] cfg;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;
   logic [DW-1:0] exp_cfg = '0;

   always #2 clk = ~clk;

   ser_cfg_port u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .sclk_i    (sclk),
      .sdin_i    (sdin),
      .slat_i    (slat),
      .test_sig_i(tsig),
      .sdout_o   (sdout),
      .cfg_o     (cfg)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   // one serial clock period; data and strobe set up a half period before the rise
   task automatic sbit(input logic d, input logic l);
      sdin = d;
      slat = l;
      wait_clk(HALF);
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
      slat = 1'b0;
   endtask

   // 22-bit transfer plus the idle load edge; optionally checks readback
   task automatic xfer(input logic [DW-1:0] d, input logic [1:0] rw, input bit latch,
                       input bit chk_rb, input logic [DW-1:0] rb, input string req);
      for (int j = 0; j < DW + 2; j++) begin
         if (chk_rb && j < DW) begin
            wait_clk(1);
            check(req, sdout, rb[DW-1-j]);
         end
         if (j < DW)        sbit(d[DW-1-j], 1'b0);
         else if (j == DW)  sbit(rw[1], 1'b0);
         else               sbit(rw[0], latch);
      end
      if (latch && rw == 2'b00) exp_cfg = d;
      sbit(~d[DW-1], 1'b0);   // load edge, its data bit is dropped
      wait_clk(HALF);
   endtask

   initial begin
      logic [DW-1:0] pats [6];
      pats[0] = 20'hA5C13; pats[1] = 20'hFFF1F; pats[2] = 20'h00000;
      pats[3] = 20'h5A21F; pats[4] = 20'h80001; pats[5] = 20'h7E01E;

      wait_clk(5);
      check("R1 cfg", cfg, 0);
      check("R1 sdout", sdout, 0);
      rst_n = 1'b1;
      wait_clk(5);
      check("R1 cfg after release", cfg, 0);

      // R2 R6 R7: write, then read back during the next transfer (select field 0)
      for (int p = 0; p < 6; p++) begin
         xfer(pats[p], 2'b00, 1'b1, 1'b0, '0, "R2");
         check("R2 write", cfg, exp_cfg);
         check("R6 load msb", sdout, exp_cfg[DW-1]);
         xfer(~pats[p], 2'b11, 1'b1, 1'b1, exp_cfg, "R7 readback");
         check("R3 read keeps cfg", cfg, exp_cfg);
      end

      // R4 mixed trailers, R5 missing latch
      xfer(20'h1234F, 2'b01, 1'b1, 1'b0, '0, "R4");
      check("R4 trailer 01", cfg, exp_cfg);
      xfer(20'h0BEEF, 2'b10, 1'b1, 1'b1, exp_cfg, "R7 after 01");
      check("R4 trailer 10", cfg, exp_cfg);
      xfer(20'h33333, 2'b00, 1'b0, 1'b0, '0, "R5");
      check("R5 no latch", cfg, exp_cfg);

      // R9: toggling data and strobe with the serial clock held low
      for (int k = 0; k < 8; k++) begin
         sdin = k[0]; slat = k[1];
         wait_clk(HALF);
         check("R9 cfg steady", cfg, exp_cfg);
         check("R9 sdout steady", sdout, exp_cfg[DW-1]);
      end
      slat = 1'b0; sdin = 1'b0;

      // R8: sweep every select value against every test input pattern
      for (int s = 1; s < 8; s++) begin
         logic [DW-1:0] w;
         w = 20'hC3A1F & ~20'h000E0;
         w[7:5] = 3'(s);
         xfer(w, 2'b00, 1'b1, 1'b0, '0, "R8");
         check("R8 write in", cfg, exp_cfg);
         for (int v = 0; v < 128; v++) begin
            tsig = 7'(v);
            wait_clk(1);
            check("R8 test route", sdout, tsig[s-1]);
         end
      end
      tsig = '0;

      // back to readback mode, then test input must have no effect
      xfer(20'hF001F, 2'b00, 1'b1, 1'b0, '0, "R8");
      check("R8 leave test mode", cfg, exp_cfg);
      for (int v = 0; v < 128; v += 9) begin
         tsig = 7'(v);
         wait_clk(1);
         check("R8 sel 0 ignores test", sdout, exp_cfg[DW-1]);
      end
      xfer(20'h00000, 2'b11, 1'b1, 1'b1, exp_cfg, "R7 final readback");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule